// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models, on the device side, the status bits a flash memory drives on its data pins while an internal program or erase is running. A command decoder outside the block reports the final write pulse of a program or erase command sequence. A separate embedded-algorithm sequencer reports suspend, resume and completion events. From these the block produces a busy toggle bit, a sector-aware toggle bit, a data-polling bit and a time-limit-exceeded bit. It also produces a flag that tells the read path whether the current read returns status or array contents.

Commands aimed only at protected sectors never reach the sequencer. For these the block runs a fixed busy window of its own, with one length for a program and another for an erase, and then returns to array reads. While an erase is suspended, reads of the sectors being erased still return status, and other sectors read as array. A program may be issued during the suspend, and the block tracks it until it finishes.

Top module: `flashStatusGen`

## Requirements
- R1: After reset, statusMode, dq7, dq6, dq5 and dq2 are all 0.
- R2: From the clock edge that samples cmdProg or cmdErase, statusMode is 1. While an operation or a protected-sector window is running, each rdStrobe cycle inverts dq6, so dq6 on the following cycle is the opposite of dq6 before the strobe.
- R3: dq6 holds its value across reads when no operation runs: in idle, after completion, and while erase is suspended.
- R4: While erase is suspended, statusMode is 1 only for reads of sectors in the erase set. A program issued during the suspend makes dq6 toggle again, and evDone returns the block to the suspended state.
- R5: A program aimed at a sector whose protMask bit is 1 makes statusMode 1 for exactly PROG_WIN cycles, counted from the edge that samples cmdProg. statusMode then returns to 0, or to the suspended behaviour if the program was issued during a suspend.
- R6: An erase whose selected sectors are all protected makes statusMode 1 for exactly ERASE_WIN cycles, and then statusMode returns to 0.
- R7: The erase set is eraseSel AND NOT protMask, captured when cmdErase is sampled. Protected selected sectors are left out of it.
- R8: dq2 inverts on an rdStrobe cycle only when rdSector is in the erase set and an erase is running or suspended. Otherwise dq2 holds.
- R9: dq7 is the complement of progDataMsb during a program, including its protected window. It is 0 during an erase and 1 while the erase is suspended.
- R10: dq5 becomes 1 once a program or erase has been active for LIMIT cycles without evDone, and it returns to 0 when evDone ends the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdProg | input | 1 | Final write pulse of a program command |
| progSector | input | SECT_W | Sector targeted by the program |
| progDataMsb | input | 1 | Top data bit being programmed |
| cmdErase | input | 1 | Final write pulse of an erase command |
| eraseSel | input | NUM_SECTORS | Sectors selected for erase |
| protMask | input | NUM_SECTORS | Per-sector protection |
| evSuspend | input | 1 | Sequencer has entered erase suspend |
| evResume | input | 1 | Sequencer resumes the erase |
| evDone | input | 1 | Sequencer has finished the current operation |
| rdStrobe | input | 1 | One read cycle |
| rdSector | input | SECT_W | Sector of the read address |
| dq7 | output | 1 | Data-polling bit |
| dq6 | output | 1 | Busy toggle bit |
| dq5 | output | 1 | Time limit exceeded |
| dq2 | output | 1 | Sector toggle bit |
| statusMode | output | 1 | Read returns status (1) or array (0) |

## Verification
A wrong operation state shows up at the next read. dq6 fails to invert when it should, or inverts when it should not, one cycle after the strobe. statusMode is also wrong in the cycle right after the command or event. A wrong erase-set capture appears as a wrong dq2 on the first read of the affected sector. A miscounted protected window or time limit moves the edge of statusMode or dq5 by at least one cycle, and the bench samples on both sides of that exact edge.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_SUSP,
    ST_SPROG,
    ST_PROTWIN
  } opStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMask;
    logic clrMask;
    logic loadData;
    logic busy;
    logic eraseTrack;
    logic suspended;
    logic progActive;
    logic timedOut;
  } ctrlStrobesT;

endpackage

// File: rtl/statCtrl.sv
module statCtrl
  import flash_stat_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int SECT_W      = $clog2(NUM_SECTORS),
  parameter int PROG_WIN    = 125,
  parameter int ERASE_WIN   = 12500,
  parameter int LIMIT       = 4000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdProg,
  input  logic [SECT_W-1:0]      progSector,
  input  logic                   cmdErase,
  input  logic [NUM_SECTORS-1:0] eraseSel,
  input  logic [NUM_SECTORS-1:0] protMask,
  input  logic                   evSuspend,
  input  logic                   evResume,
  input  logic                   evDone,
  output ctrlStrobesT            strobes
);

  localparam int WIN_MAX = (PROG_WIN > ERASE_WIN) ? PROG_WIN : ERASE_WIN;
  localparam int WIN_W   = $clog2(WIN_MAX + 1);
  localparam int LIM_W   = $clog2(LIMIT + 1);

  opStateT          state;
  logic [WIN_W-1:0] winCnt;
  logic [LIM_W-1:0] limCnt;
  logic             timedOut;
  logic             retSusp;
  logic             winProg;

  logic acceptProg, acceptErase, progProt, eraseNone, activeOp;

  assign acceptProg  = cmdProg && (state == ST_IDLE || state == ST_SUSP);
  assign acceptErase = cmdErase && (state == ST_IDLE) && !cmdProg;
  assign progProt    = protMask[progSector];
  assign eraseNone   = ((eraseSel & ~protMask) == '0);
  assign activeOp    = (state == ST_PROG) || (state == ST_ERASE) || (state == ST_SPROG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      winCnt   <= '0;
      limCnt   <= '0;
      timedOut <= 1'b0;
      retSusp  <= 1'b0;
      winProg  <= 1'b0;
    end else begin
      // time-limit counter runs while an operation is active
      if (activeOp && !timedOut) begin
        if (limCnt == LIM_W'(LIMIT - 1)) timedOut <= 1'b1;
        else                             limCnt   <= limCnt + 1'b1;
      end
      unique case (state)
        ST_IDLE: begin
          if (acceptProg) begin
            if (progProt) begin
              state   <= ST_PROTWIN;
              winCnt  <= WIN_W'(PROG_WIN - 1);
              winProg <= 1'b1;
              retSusp <= 1'b0;
            end else begin
              state    <= ST_PROG;
              limCnt   <= '0;
              timedOut <= 1'b0;
            end
          end else if (acceptErase) begin
            if (eraseNone) begin
              state   <= ST_PROTWIN;
              winCnt  <= WIN_W'(ERASE_WIN - 1);
              winProg <= 1'b0;
              retSusp <= 1'b0;
            end else begin
              state    <= ST_ERASE;
              limCnt   <= '0;
              timedOut <= 1'b0;
            end
          end
        end
        ST_PROG: begin
          if (evDone) begin
            state    <= ST_IDLE;
            timedOut <= 1'b0;
          end
        end
        ST_ERASE: begin
          if (evDone) begin
            state    <= ST_IDLE;
            timedOut <= 1'b0;
          end else if (evSuspend) begin
            state <= ST_SUSP;
          end
        end
        ST_SUSP: begin
          if (evResume) begin
            state <= ST_ERASE;
          end else if (acceptProg) begin
            if (progProt) begin
              state   <= ST_PROTWIN;
              winCnt  <= WIN_W'(PROG_WIN - 1);
              winProg <= 1'b1;
              retSusp <= 1'b1;
            end else begin
              state    <= ST_SPROG;
              limCnt   <= '0;
              timedOut <= 1'b0;
            end
          end
        end
        ST_SPROG: begin
          if (evDone) begin
            state    <= ST_SUSP;
            timedOut <= 1'b0;
          end
        end
        ST_PROTWIN: begin
          if (winCnt == '0) state <= retSusp ? ST_SUSP : ST_IDLE;
          else              winCnt <= winCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.loadMask   = acceptErase;
    strobes.clrMask    = (state == ST_ERASE) && evDone;
    strobes.loadData   = acceptProg;
    strobes.busy       = activeOp || (state == ST_PROTWIN);
    strobes.eraseTrack = (state == ST_ERASE) || (state == ST_SUSP) ||
                         (state == ST_SPROG) || ((state == ST_PROTWIN) && retSusp);
    strobes.suspended  = (state == ST_SUSP);
    strobes.progActive = (state == ST_PROG) || (state == ST_SPROG) ||
                         ((state == ST_PROTWIN) && winProg);
    strobes.timedOut   = timedOut;
  end

endmodule

// File: rtl/statDatapath.sv
module statDatapath
  import flash_stat_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int SECT_W      = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobesT            strobes,
  input  logic                   progDataMsb,
  input  logic [NUM_SECTORS-1:0] eraseSel,
  input  logic [NUM_SECTORS-1:0] protMask,
  input  logic                   rdStrobe,
  input  logic [SECT_W-1:0]      rdSector,
  output logic                   dq7,
  output logic                   dq6,
  output logic                   dq5,
  output logic                   dq2,
  output logic                   statusMode
);

  logic [NUM_SECTORS-1:0] maskQ;
  logic                   dataQ;
  logic                   tglBusyQ;
  logic                   tglSectQ;
  logic                   sectHit;

  assign sectHit = maskQ[rdSector];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ    <= '0;
      dataQ    <= 1'b0;
      tglBusyQ <= 1'b0;
      tglSectQ <= 1'b0;
    end else begin
      if (strobes.loadMask)     maskQ <= eraseSel & ~protMask;
      else if (strobes.clrMask) maskQ <= '0;
      if (strobes.loadData) dataQ <= progDataMsb;
      if (rdStrobe && strobes.busy) tglBusyQ <= ~tglBusyQ;
      if (rdStrobe && strobes.eraseTrack && sectHit) tglSectQ <= ~tglSectQ;
    end
  end

  always_comb begin
    if (strobes.progActive)     dq7 = ~dataQ;
    else if (strobes.suspended) dq7 = 1'b1;
    else                        dq7 = 1'b0;
  end

  assign dq6        = tglBusyQ;
  assign dq2        = tglSectQ;
  assign dq5        = strobes.timedOut;
  assign statusMode = strobes.busy || (strobes.suspended && sectHit);

endmodule

// File: rtl/flashStatusGen.sv
module flashStatusGen
  import flash_stat_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int SECT_W      = $clog2(NUM_SECTORS),
  parameter int PROG_WIN    = 125,
  parameter int ERASE_WIN   = 12500,
  parameter int LIMIT       = 4000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdProg,
  input  logic [SECT_W-1:0]      progSector,
  input  logic                   progDataMsb,
  input  logic                   cmdErase,
  input  logic [NUM_SECTORS-1:0] eraseSel,
  input  logic [NUM_SECTORS-1:0] protMask,
  input  logic                   evSuspend,
  input  logic                   evResume,
  input  logic                   evDone,
  input  logic                   rdStrobe,
  input  logic [SECT_W-1:0]      rdSector,
  output logic                   dq7,
  output logic                   dq6,
  output logic                   dq5,
  output logic                   dq2,
  output logic                   statusMode
);

  ctrlStrobesT ctrlStb;

  statCtrl #(
    .NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W), .PROG_WIN(PROG_WIN),
    .ERASE_WIN(ERASE_WIN), .LIMIT(LIMIT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdProg(cmdProg), .progSector(progSector),
    .cmdErase(cmdErase), .eraseSel(eraseSel), .protMask(protMask),
    .evSuspend(evSuspend), .evResume(evResume), .evDone(evDone),
    .strobes(ctrlStb)
  );

  statDatapath #(
    .NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(ctrlStb), .progDataMsb(progDataMsb),
    .eraseSel(eraseSel), .protMask(protMask), .rdStrobe(rdStrobe),
    .rdSector(rdSector), .dq7(dq7), .dq6(dq6), .dq5(dq5), .dq2(dq2),
    .statusMode(statusMode)
  );

endmodule

// File: rtl/statGenChecker.sv
module statGenChecker #(
  parameter int NUM_SECTORS = 8,
  parameter int SECT_W      = $clog2(NUM_SECTORS)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cmdProg,
  input logic [SECT_W-1:0]      progSector,
  input logic [NUM_SECTORS-1:0] protMask,
  input logic                   rdStrobe,
  input logic                   busy,
  input logic                   suspended,
  input logic                   dq6,
  input logic                   dq5,
  input logic                   dq2,
  input logic                   statusMode
);

  assert_dq6_flip_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && busy) |=> (dq6 != $past(dq6)));

  assert_dq6_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy) |=> $stable(dq6));

  assert_dq2_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobe) |=> $stable(dq2));

  assert_prot_prog_status_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdProg && protMask[progSector] && !busy && !suspended) |=> statusMode);

  assert_dq5_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dq5) |-> $past(busy));

endmodule

bind flashStatusGen statGenChecker #(
  .NUM_SECTORS(NUM_SECTORS), .SECT_W(SECT_W)
) i_statGenChecker (
  .clk(clk), .rstN(rstN), .cmdProg(cmdProg), .progSector(progSector),
  .protMask(protMask), .rdStrobe(rdStrobe), .busy(ctrlStb.busy),
  .suspended(ctrlStb.suspended), .dq6(dq6), .dq5(dq5), .dq2(dq2),
  .statusMode(statusMode)
);

// File: tb/test_flashStatusGen.sv
module test_flashStatusGen;

  localparam int NS        = 8;
  localparam int SW        = 3;
  localparam int PROG_WIN  = 16;
  localparam int ERASE_WIN = 200;
  localparam int LIMIT     = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdProg = 0, progDataMsb = 0, cmdErase = 0;
  logic evSuspend = 0, evResume = 0, evDone = 0, rdStrobe = 0;
  logic [SW-1:0] progSector = '0, rdSector = '0;
  logic [NS-1:0] eraseSel = '0, protMask = 8'h81;
  logic dq7, dq6, dq5, dq2, statusMode;

  int errors = 0;
  int checks = 0;
  logic prev6, prev2;

  always #4 clk = ~clk;

  flashStatusGen #(
    .NUM_SECTORS(NS), .SECT_W(SW), .PROG_WIN(PROG_WIN),
    .ERASE_WIN(ERASE_WIN), .LIMIT(LIMIT)
  ) i_flashStatusGen (
    .clk(clk), .rstN(rstN), .cmdProg(cmdProg), .progSector(progSector),
    .progDataMsb(progDataMsb), .cmdErase(cmdErase), .eraseSel(eraseSel),
    .protMask(protMask), .evSuspend(evSuspend), .evResume(evResume),
    .evDone(evDone), .rdStrobe(rdStrobe), .rdSector(rdSector),
    .dq7(dq7), .dq6(dq6), .dq5(dq5), .dq2(dq2), .statusMode(statusMode)
  );

  // sector (bits 3:1) and whether dq2 must invert (bit 0), erase set 0x0E
  localparam logic [3:0] VEC [6] = '{
    {3'd1, 1'b1}, {3'd0, 1'b0}, {3'd5, 1'b0},
    {3'd3, 1'b1}, {3'd7, 1'b0}, {3'd2, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [SW-1:0] s);
    prev6 = dq6;
    prev2 = dq2;
    rdSector = s;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic prog(input logic [SW-1:0] s, input logic d);
    progSector = s;
    progDataMsb = d;
    cmdProg = 1'b1;
    @(negedge clk);
    cmdProg = 1'b0;
  endtask

  task automatic erase(input logic [NS-1:0] sel);
    eraseSel = sel;
    cmdErase = 1'b1;
    @(negedge clk);
    cmdErase = 1'b0;
  endtask

  task automatic pulseDone();
    evDone = 1'b1;
    @(negedge clk);
    evDone = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    check("R1 statusMode", statusMode, 1'b0);
    check("R1 dq6", dq6, 1'b0);
    check("R1 dq5", dq5, 1'b0);
    check("R1 dq2", dq2, 1'b0);
    check("R1 dq7", dq7, 1'b0);

    // R3 idle read keeps dq6
    rd(3);
    check("R3 idle dq6", dq6, prev6);
    check("R3 idle status", statusMode, 1'b0);

    // R2 / R9 normal program
    prog(3'd1, 1'b1);
    check("R2 status after cmd", statusMode, 1'b1);
    check("R9 dq7 program", dq7, 1'b0);
    for (int k = 0; k < 3; k++) begin
      rd(3'd4);
      check("R2 dq6 flip", dq6, ~prev6);
    end
    pulseDone();
    rd(3'd4);
    check("R3 done dq6", dq6, prev6);
    check("R3 done status", statusMode, 1'b0);

    // R10 time limit
    prog(3'd2, 1'b0);
    check("R9 dq7 program0", dq7, 1'b1);
    cyc(LIMIT - 1);
    check("R10 dq5 before", dq5, 1'b0);
    cyc(1);
    check("R10 dq5 after", dq5, 1'b1);
    pulseDone();
    check("R10 dq5 cleared", dq5, 1'b0);

    // R5 protected program window
    prog(3'd0, 1'b1);
    rd(3'd0);
    check("R5 dq6 flip in window", dq6, ~prev6);
    check("R9 dq7 in window", dq7, 1'b0);
    cyc(PROG_WIN - 2);
    check("R5 window last", statusMode, 1'b1);
    cyc(1);
    check("R5 window end", statusMode, 1'b0);

    // R6 all-protected erase window
    erase(8'h81);
    check("R6 window start", statusMode, 1'b1);
    cyc(ERASE_WIN - 1);
    check("R6 window last", statusMode, 1'b1);
    cyc(1);
    check("R6 window end", statusMode, 1'b0);

    // R7 / R8 partial erase, table walk
    erase(8'h0F);
    check("R9 dq7 erase", dq7, 1'b0);
    for (int v = 0; v < 6; v++) begin
      rd(VEC[v][3:1]);
      check("R2 erase dq6 flip", dq6, ~prev6);
      check(VEC[v][0] ? "R7 dq2 flip" : "R8 dq2 hold", dq2, prev2 ^ VEC[v][0]);
    end

    // R4 suspend
    evSuspend = 1'b1;
    cyc(1);
    evSuspend = 1'b0;
    check("R9 dq7 suspended", dq7, 1'b1);
    rdSector = 3'd2;
    #1;
    check("R4 status erase sector", statusMode, 1'b1);
    rdSector = 3'd5;
    #1;
    check("R4 array other sector", statusMode, 1'b0);
    rd(3'd2);
    check("R3 suspend dq6", dq6, prev6);
    check("R8 suspended dq2 flip", dq2, ~prev2);
    rd(3'd6);
    check("R8 dq2 hold outside", dq2, prev2);

    // R4 program during suspend
    prog(3'd5, 1'b1);
    rd(3'd5);
    check("R4 suspend-program dq6 flip", dq6, ~prev6);
    check("R9 dq7 suspend-program", dq7, 1'b0);
    pulseDone();
    check("R4 back to suspend", dq7, 1'b1);
    rd(3'd5);
    check("R4 dq6 stops", dq6, prev6);

    // resume and finish
    evResume = 1'b1;
    cyc(1);
    evResume = 1'b0;
    rd(3'd3);
    check("R2 resumed dq6 flip", dq6, ~prev6);
    check("R8 resumed dq2 flip", dq2, ~prev2);
    pulseDone();
    rdSector = 3'd3;
    #1;
    check("R7 erase set cleared", statusMode, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule